// File: doc/BRIEF.md
# Dual Voltage-Output Converter Register Interface

This block is the digital side of two independent 8-bit voltage-output converters. A byte-wide register bus (address, write data, write strobe, registered read data) reaches two code registers and one shared control register. The block drives each code and an output-enable to an external resistor ladder. Each ladder produces a voltage of reference × code / 256, for codes 0 to 255. The block also drives a line that connects the reference to the ladders or cuts it off.

Software may cut the reference off so that the ladders draw no current, but only while the expansion-enable input is high. When the reference is connected again, it needs at least one microsecond to settle. An internal timer covers that interval, and the ready output tells the rest of the system when a conversion may begin. The timer length is derived from a clock-frequency parameter.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset both codes are 0x00, both output-enables are 0, ref_disconnect is 1, conv_ready is 0 and rd_data is 0x00.
- R2: A write to address 0x68 (channel 0) or 0x6A (channel 1) sets that channel's code from the next clock edge, whether or not the channel is enabled. The other channel's code is left unchanged.
- R3: A write to the control address 0x1F sets ch0_oe from write-data bit 7 and ch1_oe from bit 6, with 1 meaning enabled. The output-enables change only on such a write.
- R4: Control bit 5 (1 = reference disconnected) takes the written value only when exp_en is 1. When exp_en is 0, the write leaves ref_disconnect unchanged.
- R5: After ref_disconnect falls from 1 to 0, conv_ready rises exactly SETTLE clock cycles later, where SETTLE = ceil(CLK_HZ × 1 µs). It stays low until then.
- R6: conv_ready is 0 during every cycle in which ref_disconnect is 1, and it falls on the same edge that sets ref_disconnect.
- R7: The read data is registered and appears one cycle after the address is presented. Address 0x68 returns the channel 0 code and 0x6A returns the channel 1 code. Address 0x1F returns {ch0_oe, ch1_oe, ref_disconnect, 5'b0}. Every other address returns 0x00.
- R8: Control write-data bits 4 to 0 change no output and always read back as 0.
- R9: A write to an unmapped address changes no code, enable or reference output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_en | input | 1 | Expansion enable; allows writes to the reference bit |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_data | output | 8 | Registered read data |
| ch0_code | output | 8 | Code to ladder 0 |
| ch1_code | output | 8 | Code to ladder 1 |
| ch0_oe | output | 1 | Output enable, channel 0 |
| ch1_oe | output | 1 | Output enable, channel 1 |
| ref_disconnect | output | 1 | 1 = reference cut off from the ladders |
| conv_ready | output | 1 | Reference connected and settled |

## Verification
The code and enable registers drive the ports directly, so a wrong bit in them shows on the ladder outputs on the edge after the write. It also shows in the read-back one cycle later. A wrong settle count shows as conv_ready rising too early or too late, which the bench measures to the exact cycle after the reference is reconnected. A reference bit that can be written with the expansion input low shows at once on ref_disconnect and drops conv_ready on the same edge.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam logic [7:0] ADR_CODE0 = 8'h68;
  localparam logic [7:0] ADR_CODE1 = 8'h6A;
  localparam logic [7:0] ADR_CTRL  = 8'h1F;
  localparam int         NUM_CH    = 2;

  // cycles that cover a delay of dly_ns at clk_hz, rounded up, at least 1
  function automatic int settle_cycles(longint clk_hz, longint dly_ns);
    longint c;
    c = (clk_hz * dly_ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/dac_regs.sv
module dac_regs
  import dac_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exp_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] code   [NUM_CH],
  output logic              oe     [NUM_CH],
  output logic              ref_off
);
  localparam int REF_BIT = DATA_W - 1 - NUM_CH;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ADR_CTRL);

  logic sel_ctrl;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] ctrl_view;
  logic [NUM_CH-1:0] hit;

  assign sel_ctrl = (addr == CTRL_A);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_A =
      ADDR_W'((i == 0) ? ADR_CODE0 : ADR_CODE1);
    assign hit[i] = (addr == CH_A);

    always_ff @(posedge clk) begin
      if (rst) begin
        code[i] <= '0;
        oe[i]   <= 1'b0;
      end else begin
        if (wr_en && hit[i])   code[i] <= wdata;
        if (wr_en && sel_ctrl) oe[i]   <= wdata[DATA_W-1-i];
      end
    end

    assign ctrl_view[DATA_W-1-i] = oe[i];
  end

  assign ctrl_view[REF_BIT]     = ref_off;
  assign ctrl_view[REF_BIT-1:0] = '0;

  always_ff @(posedge clk) begin
    if (rst)                             ref_off <= 1'b1;
    else if (wr_en && sel_ctrl && exp_en) ref_off <= wdata[REF_BIT];
  end

  always_comb begin
    rd_next = '0;
    if (sel_ctrl) rd_next = ctrl_view;
    for (int i = 0; i < NUM_CH; i++)
      if (hit[i]) rd_next = code[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/dac_settle_timer.sv
module dac_settle_timer #(
  parameter int SETTLE = 125,
  localparam int CNT_W = $clog2(SETTLE + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_off,
  output logic ready
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || ref_off) cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign ready = !ref_off && (cnt == '0);
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_pkg::*;
#(
  parameter longint CLK_HZ   = 125_000_000,
  parameter longint SETTLE_NS = 1000,
  parameter int     ADDR_W   = 8,
  parameter int     DATA_W   = 8,
  localparam int    SETTLE   = settle_cycles(CLK_HZ, SETTLE_NS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exp_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ch0_code,
  output logic [DATA_W-1:0] ch1_code,
  output logic              ch0_oe,
  output logic              ch1_oe,
  output logic              ref_disconnect,
  output logic              conv_ready
);
  logic [DATA_W-1:0] code [NUM_CH];
  logic              oe   [NUM_CH];

  dac_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .exp_en(exp_en), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_data(rd_data), .code(code), .oe(oe),
    .ref_off(ref_disconnect)
  );

  dac_settle_timer #(.SETTLE(SETTLE)) i_timer (
    .clk(clk), .rst(rst), .ref_off(ref_disconnect), .ready(conv_ready)
  );

  assign ch0_code = code[0];
  assign ch1_code = code[1];
  assign ch0_oe   = oe[0];
  assign ch1_oe   = oe[1];
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
  import dac_pkg::*;
#(
  parameter int SETTLE = 125,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              exp_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] ch0_code,
  input logic [DATA_W-1:0] ch1_code,
  input logic              ch0_oe,
  input logic              ch1_oe,
  input logic              ref_disconnect,
  input logic              conv_ready
);
  localparam int W = $clog2(SETTLE + 2);
  logic [W-1:0] since_conn;
  logic mapped;

  assign mapped = (addr == ADDR_W'(ADR_CODE0)) || (addr == ADDR_W'(ADR_CODE1)) ||
                  (addr == ADDR_W'(ADR_CTRL));

  always_ff @(posedge clk) begin
    if (rst || ref_disconnect) since_conn <= '0;
    else if (since_conn != W'(SETTLE + 1)) since_conn <= since_conn + 1'b1;
  end

  AST_READY_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    conv_ready |-> !ref_disconnect); // R6
  AST_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_ready) |-> (since_conn == W'(SETTLE))); // R5
  AST_REF_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !exp_en |=> $stable(ref_disconnect)); // R4
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(ADR_CTRL)) |=> ($stable(ch0_oe) && $stable(ch1_oe))); // R3
  AST_CODE0_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(ADR_CODE0)) |=> $stable(ch0_code)); // R2
  AST_CODE1_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(ADR_CODE1)) |=> $stable(ch1_code)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (rd_data == '0)); // R7
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(
  .SETTLE(SETTLE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst(rst), .exp_en(exp_en), .addr(addr), .wr_en(wr_en),
  .rd_data(rd_data), .ch0_code(ch0_code), .ch1_code(ch1_code),
  .ch0_oe(ch0_oe), .ch1_oe(ch1_oe), .ref_disconnect(ref_disconnect),
  .conv_ready(conv_ready)
);

// File: tb/test_dual_dac_ctrl.sv
module test_dual_dac_ctrl;
  localparam longint CLK_HZ = 12_500_000;
  localparam int EXP_SETTLE = 13; // ceil(12.5 cycles)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exp_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0;
  logic [7:0] rd_data, ch0_code, ch1_code;
  logic ch0_oe, ch1_oe, ref_disconnect, conv_ready;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_dac_ctrl #(.CLK_HZ(CLK_HZ)) i_dual_dac_ctrl (
    .clk(clk), .rst(rst), .exp_en(exp_en), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_data(rd_data), .ch0_code(ch0_code), .ch1_code(ch1_code),
    .ch0_oe(ch0_oe), .ch1_oe(ch1_oe), .ref_disconnect(ref_disconnect),
    .conv_ready(conv_ready)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic state_check(string req, int c0, int c1, int o0, int o1, int r);
    check({req, " ch0_code"}, ch0_code, c0);
    check({req, " ch1_code"}, ch1_code, c1);
    check({req, " ch0_oe"}, ch0_oe, o0);
    check({req, " ch1_oe"}, ch1_oe, o1);
    check({req, " ref"}, ref_disconnect, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int ref_exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    state_check("R1", 0, 0, 0, 0, 1);
    check("R1 ready", conv_ready, 0);
    check("R1 rd_data", rd_data, 0);

    // R2 / R7 code sweeps on both channels, disabled outputs
    for (int n = 0; n < 256; n++) begin
      wr(8'h68, 8'(n));
      check("R2 ch0 code", ch0_code, n);
      check("R2 ch1 untouched", ch1_code, (n == 0) ? 0 : 255 - (n - 1));
      wr(8'h6A, 8'(255 - n));
      check("R2 ch1 code", ch1_code, 255 - n);
      check("R2 ch0 untouched", ch0_code, n);
      rd(8'h68, d); check("R7 read ch0", d, n);
      rd(8'h6A, d); check("R7 read ch1", d, 255 - n);
    end

    // R3 / R4 / R8 control sweep with expansion disabled
    exp_en = 1'b0;
    ref_exp = 1;
    for (int v = 0; v < 256; v++) begin
      wr(8'h1F, 8'(v));
      check("R3 ch0_oe", ch0_oe, (v >> 7) & 1);
      check("R3 ch1_oe", ch1_oe, (v >> 6) & 1);
      check("R4 ref locked", ref_disconnect, ref_exp);
      check("R8 codes", {ch0_code, ch1_code}, {8'd255, 8'd0});
      rd(8'h1F, d);
      check("R8 ctrl readback", d, (v & 8'hC0) | (ref_exp << 5));
    end

    // R4 / R8 control sweep with expansion enabled
    exp_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(8'h1F, 8'(v));
      ref_exp = (v >> 5) & 1;
      check("R4 ref writable", ref_disconnect, ref_exp);
      check("R3 ch0_oe", ch0_oe, (v >> 7) & 1);
      check("R3 ch1_oe", ch1_oe, (v >> 6) & 1);
      rd(8'h1F, d);
      check("R8 ctrl readback", d, v & 8'hE0);
    end

    // R5 settle timing from reconnect
    wr(8'h1F, 8'h20);
    check("R6 ready low when off", conv_ready, 0);
    wr(8'h1F, 8'hC0);  // reconnect at edge E0, now just after E0
    for (int k = 0; k <= EXP_SETTLE + 3; k++) begin
      check("R5 settle ready", conv_ready, (k >= EXP_SETTLE) ? 1 : 0);
      @(negedge clk);
    end

    // R4 expansion off: attempt to disconnect is ignored, ready stays high
    exp_en = 1'b0;
    wr(8'h1F, 8'hE0);
    check("R4 ref unchanged", ref_disconnect, 0);
    check("R4 ready kept", conv_ready, 1);

    // R6 disconnect drops ready on the same edge
    exp_en = 1'b1;
    wr(8'h1F, 8'hE0);
    check("R6 ref set", ref_disconnect, 1);
    check("R6 ready dropped", conv_ready, 0);
    wr(8'h1F, 8'h40);  // reconnect, ch1 only enabled

    // R9 / R7 unmapped addresses: writes ignored, reads zero
    wr(8'h68, 8'h3C);
    wr(8'h6A, 8'hC3);
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h68 || a == 8'h6A || a == 8'h1F) continue;
      wr(8'(a), 8'hFF);
      state_check("R9", 8'h3C, 8'hC3, 0, 1, 0);
      rd(8'(a), d);
      check("R7 unmapped read", d, 0);
    end

    // R5 ready eventually reached after reconnect
    check("R5 ready after sweep", conv_ready, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule